// File: doc/BRIEF.md
# Full-Track Read Sequencer

This block controls a disk-controller command that reads every data field of one track in turn. It starts at the index pulse and takes no account of logical sector numbers. Once a command is accepted, the block waits for the index pulse and then raises a transfer enable for the data path. While the transfer runs it receives ID-field and data-field events from the bit decoder. Each ID is compared with the ID the command expects. CRC problems and ID mismatches are recorded but never stop the read. The block counts the data fields it has read.

The command ends normally once the count reaches the command's sector limit. It ends abnormally when two index pulses in a row pass with no ID mark between them. A command that requests multi-track or skip operation is rejected as soon as it is issued. Every ending produces a single-cycle done strobe. The interrupt code and status flags are then held until the next command is accepted.

Top module: `track_read_seq`

## Requirements
- R1: After reset, `xfer_en`, `done`, `st_nd`, `st_ma` and `st_crc` are 0, `int_code` is 2'b00 and `sect_cnt` is 0.
- R2: If `cmd_start` arrives while idle with `cmd_mt` or `cmd_sk` at 1, the command is rejected. In the next cycle `done` is 1, `int_code` is 2'b10, the flags and `sect_cnt` are 0, and `xfer_en` stays 0, even when index pulses follow.
- R3: After an accepted command, `xfer_en` stays 0 and data-field events are not counted until an index pulse arrives. `xfer_en` goes to 1 in the cycle after that pulse.
- R4: While reading, `sect_cnt` increases by one in the cycle after each `data_end`. In the cycle after the `data_end` that brings the count to `eot_cnt`, `done` is 1, `xfer_en` is 0 and `int_code` is 2'b00 (normal).
- R5: An ID event whose value differs from `exp_id` sets `st_nd`, and reading continues with `xfer_en` still 1.
- R6: A CRC error flagged on an ID event or on a data-field event sets `st_crc`, and reading continues.
- R7: While reading, an index pulse ends the command in the following cycle when no ID event has arrived since the previous index pulse. The starting index pulse counts as a previous pulse. `done` is then 1, `int_code` is 2'b01 and `st_ma` is 1, and `sect_cnt` keeps its value. An ID event resets this pulse count.
- R8: `done` lasts exactly one cycle. `int_code`, the flags and `sect_cnt` keep their values until the next accepted `cmd_start`, which clears them in the following cycle.
- R9: A `cmd_start` that arrives while a command is active is ignored.
- R10: If the final `data_end` and a timing-out index pulse arrive in the same cycle, the command ends normally with `int_code` 2'b00 and `st_ma` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle command issue strobe |
| cmd_mt | input | 1 | Multi-track request bit of the command (must be 0) |
| cmd_sk | input | 1 | Skip request bit of the command (must be 0) |
| exp_id | input | ID_W | ID value the command expects |
| eot_cnt | input | CNT_W | Number of data fields to read |
| index_pulse | input | 1 | One-cycle index event |
| id_valid | input | 1 | One-cycle ID-field event |
| id_value | input | ID_W | ID-field contents, valid with `id_valid` |
| id_crc_err | input | 1 | ID-field CRC error, valid with `id_valid` |
| data_end | input | 1 | One-cycle end-of-data-field event |
| data_crc_err | input | 1 | Data-field CRC error, valid with `data_end` |
| xfer_en | output | 1 | Data transfer enable |
| sect_cnt | output | CNT_W | Data fields read in this command |
| done | output | 1 | One-cycle completion strobe |
| int_code | output | 2 | 00 normal, 01 abnormal, 10 invalid command |
| st_nd | output | 1 | ID mismatch seen |
| st_ma | output | 1 | Missing address mark timeout |
| st_crc | output | 1 | CRC error seen in an ID or data field |

## Verification
Every result is registered once, so each output reflects an input event in the clock cycle that follows the edge which sampled it. This applies to the enable after the index pulse, the count and flags after ID and data events, and the done strobe with its code after the final event or timeout. The bench drives each event for one cycle just after a rising edge. It samples one time unit after the next rising edge, which is exactly where the result is due. It then holds idle for several cycles to confirm that nothing moves until the next command.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ARM  = 2'd1,
    S_READ = 2'd2
  } trk_state_e;

  localparam logic [1:0] IC_NORMAL  = 2'b00;
  localparam logic [1:0] IC_ABNORM  = 2'b01;
  localparam logic [1:0] IC_INVALID = 2'b10;
endpackage

// File: rtl/trk_sect_count.sv
module trk_sect_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  input  logic [CNT_W-1:0] eot,
  output logic [CNT_W-1:0] count,
  output logic             last
);
  logic [CNT_W:0] nxt;

  assign nxt  = {1'b0, count} + 1'b1;
  assign last = inc && (nxt >= {1'b0, eot});

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/trk_idx_watch.sv
module trk_idx_watch #(
  parameter int PULSES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic load_first,
  input  logic active,
  input  logic index_pulse,
  input  logic id_seen,
  output logic timeout
);
  localparam int W = $clog2(PULSES + 1);
  localparam logic [W-1:0] LIMIT = W'(PULSES - 1);

  logic [W-1:0] cnt;

  assign timeout = active && index_pulse && !id_seen && (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (load_first) begin
      cnt <= W'(1);
    end else if (active) begin
      if (id_seen) begin
        cnt <= index_pulse ? W'(1) : '0;
      end else if (index_pulse && (cnt != LIMIT)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trk_flag_acc.sv
module trk_flag_acc #(
  parameter int ID_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            active,
  input  logic            id_valid,
  input  logic [ID_W-1:0] id_value,
  input  logic [ID_W-1:0] exp_id,
  input  logic            id_crc_err,
  input  logic            data_end,
  input  logic            data_crc_err,
  output logic            nd,
  output logic            crc
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      nd  <= 1'b0;
      crc <= 1'b0;
    end else if (active) begin
      if (id_valid && (id_value != exp_id)) begin
        nd <= 1'b1;
      end
      if ((id_valid && id_crc_err) || (data_end && data_crc_err)) begin
        crc <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/track_read_seq.sv
module track_read_seq
  import trk_pkg::*;
#(
  parameter int ID_W   = 32,
  parameter int CNT_W  = 8,
  parameter int PULSES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic             cmd_mt,
  input  logic             cmd_sk,
  input  logic [ID_W-1:0]  exp_id,
  input  logic [CNT_W-1:0] eot_cnt,
  input  logic             index_pulse,
  input  logic             id_valid,
  input  logic [ID_W-1:0]  id_value,
  input  logic             id_crc_err,
  input  logic             data_end,
  input  logic             data_crc_err,
  output logic             xfer_en,
  output logic [CNT_W-1:0] sect_cnt,
  output logic             done,
  output logic [1:0]       int_code,
  output logic             st_nd,
  output logic             st_ma,
  output logic             st_crc
);
  trk_state_e state_q;

  logic idle_w;
  logic reading;
  logic accept;
  logic reject;
  logic start_rd;
  logic fin_ok;
  logic to_ma;
  logic fin_ma;

  assign idle_w   = (state_q == S_IDLE);
  assign reading  = (state_q == S_READ);
  assign accept   = idle_w && cmd_start && !cmd_mt && !cmd_sk;
  assign reject   = idle_w && cmd_start && (cmd_mt || cmd_sk);
  assign start_rd = (state_q == S_ARM) && index_pulse;
  assign fin_ma   = to_ma && !fin_ok;

  trk_sect_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (accept || reject),
    .inc   (reading && data_end),
    .eot   (eot_cnt),
    .count (sect_cnt),
    .last  (fin_ok)
  );

  trk_idx_watch #(.PULSES(PULSES)) u_idx (
    .clk         (clk),
    .rst         (rst),
    .clear       (accept || reject),
    .load_first  (start_rd),
    .active      (reading),
    .index_pulse (index_pulse),
    .id_seen     (id_valid),
    .timeout     (to_ma)
  );

  trk_flag_acc #(.ID_W(ID_W)) u_flg (
    .clk          (clk),
    .rst          (rst),
    .clear        (accept || reject),
    .active       (reading),
    .id_valid     (id_valid),
    .id_value     (id_value),
    .exp_id       (exp_id),
    .id_crc_err   (id_crc_err),
    .data_end     (data_end),
    .data_crc_err (data_crc_err),
    .nd           (st_nd),
    .crc          (st_crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      xfer_en  <= 1'b0;
      done     <= 1'b0;
      int_code <= IC_NORMAL;
      st_ma    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            state_q  <= S_ARM;
            int_code <= IC_NORMAL;
            st_ma    <= 1'b0;
          end else if (reject) begin
            done     <= 1'b1;
            int_code <= IC_INVALID;
            st_ma    <= 1'b0;
          end
        end
        S_ARM: begin
          if (index_pulse) begin
            state_q <= S_READ;
            xfer_en <= 1'b1;
          end
        end
        S_READ: begin
          if (fin_ok) begin
            state_q  <= S_IDLE;
            xfer_en  <= 1'b0;
            done     <= 1'b1;
            int_code <= IC_NORMAL;
          end else if (fin_ma) begin
            state_q  <= S_IDLE;
            xfer_en  <= 1'b0;
            done     <= 1'b1;
            int_code <= IC_ABNORM;
            st_ma    <= 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trk_read_chk.sv
module trk_read_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_start,
  input logic             cmd_mt,
  input logic             cmd_sk,
  input logic             idle,
  input logic             xfer_en,
  input logic             done,
  input logic [1:0]       int_code,
  input logic             st_nd,
  input logic             st_ma,
  input logic             st_crc,
  input logic [CNT_W-1:0] sect_cnt
);
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_reject_r2: assert property (@(posedge clk) disable iff (rst)
    (idle && cmd_start && (cmd_mt || cmd_sk)) |=> (done && int_code == 2'b10 && !xfer_en));

  p_ma_code_r7: assert property (@(posedge clk) disable iff (rst)
    st_ma |-> (int_code == 2'b01));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (idle && !cmd_start) |=> ($stable(int_code) && $stable(st_nd) && $stable(st_crc)
                              && $stable(st_ma) && $stable(sect_cnt)));

  p_xfer_off_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !xfer_en);

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    xfer_en |=> ((sect_cnt == $past(sect_cnt)) || (sect_cnt == $past(sect_cnt) + 1'b1)));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (!idle && cmd_start && (cmd_mt || cmd_sk)) |=> !(done && int_code == 2'b10));
endmodule

bind track_read_seq trk_read_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_start (cmd_start),
  .cmd_mt    (cmd_mt),
  .cmd_sk    (cmd_sk),
  .idle      (idle_w),
  .xfer_en   (xfer_en),
  .done      (done),
  .int_code  (int_code),
  .st_nd     (st_nd),
  .st_ma     (st_ma),
  .st_crc    (st_crc),
  .sect_cnt  (sect_cnt)
);

// File: tb/track_read_seq_tb.sv
`timescale 1ns/1ps
module track_read_seq_tb;
  localparam int ID_W  = 32;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             cmd_start, cmd_mt, cmd_sk;
  logic [ID_W-1:0]  exp_id;
  logic [CNT_W-1:0] eot_cnt;
  logic             index_pulse, id_valid, id_crc_err, data_end, data_crc_err;
  logic [ID_W-1:0]  id_value;
  logic             xfer_en, done, st_nd, st_ma, st_crc;
  logic [CNT_W-1:0] sect_cnt;
  logic [1:0]       int_code;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  track_read_seq #(.ID_W(ID_W), .CNT_W(CNT_W), .PULSES(2)) u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_mt(cmd_mt), .cmd_sk(cmd_sk),
    .exp_id(exp_id), .eot_cnt(eot_cnt), .index_pulse(index_pulse), .id_valid(id_valid),
    .id_value(id_value), .id_crc_err(id_crc_err), .data_end(data_end),
    .data_crc_err(data_crc_err), .xfer_en(xfer_en), .sect_cnt(sect_cnt), .done(done),
    .int_code(int_code), .st_nd(st_nd), .st_ma(st_ma), .st_crc(st_crc)
  );

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clr_in();
    cmd_start = 0; cmd_mt = 0; cmd_sk = 0;
    index_pulse = 0; id_valid = 0; id_crc_err = 0; id_value = '0;
    data_end = 0; data_crc_err = 0;
  endtask

  task automatic do_reset();
    clr_in();
    rst = 1;
    tick(); tick();
    rst = 0;
  endtask

  task automatic start(input logic mt, input logic sk, input int eot);
    eot_cnt = CNT_W'(eot); cmd_mt = mt; cmd_sk = sk; cmd_start = 1;
    tick();
    clr_in();
  endtask

  task automatic ev_index();
    index_pulse = 1; tick(); clr_in();
  endtask

  task automatic ev_id(input logic [ID_W-1:0] v, input logic crc);
    id_valid = 1; id_value = v; id_crc_err = crc; tick(); clr_in();
  endtask

  task automatic ev_data(input logic crc);
    data_end = 1; data_crc_err = crc; tick(); clr_in();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "xfer_en", xfer_en, 0);
    chk("R1", "done", done, 0);
    chk("R1", "int_code", int_code, 0);
    chk("R1", "flags", {st_nd, st_ma, st_crc}, 0);
    chk("R1", "sect_cnt", sect_cnt, 0);
  endtask

  task automatic t_reject();
    do_reset();
    start(1, 0, 3);
    chk("R2", "done mt", done, 1);
    chk("R2", "int_code mt", int_code, 2);
    chk("R2", "xfer_en mt", xfer_en, 0);
    chk("R2", "sect_cnt mt", sect_cnt, 0);
    ev_index();
    chk("R2", "xfer_en after index", xfer_en, 0);
    chk("R8", "done single", done, 0);
    start(0, 1, 3);
    chk("R2", "done sk", done, 1);
    chk("R2", "int_code sk", int_code, 2);
  endtask

  task automatic t_normal();
    do_reset();
    exp_id = 32'h0000_0121;
    start(0, 0, 3);
    chk("R3", "xfer before index", xfer_en, 0);
    ev_data(0);
    chk("R3", "count before index", sect_cnt, 0);
    ev_index();
    chk("R3", "xfer after index", xfer_en, 1);
    ev_id(32'h0000_0121, 0);
    chk("R5", "nd on match", st_nd, 0);
    ev_data(0);
    chk("R4", "count 1", sect_cnt, 1);
    ev_id(32'h0000_0155, 0);
    chk("R5", "nd on mismatch", st_nd, 1);
    chk("R5", "xfer continues", xfer_en, 1);
    ev_data(1);
    chk("R6", "crc on data", st_crc, 1);
    chk("R4", "count 2", sect_cnt, 2);
    chk("R6", "no done on crc", done, 0);
    ev_id(32'h0000_0121, 1);
    ev_data(0);
    chk("R4", "done at eot", done, 1);
    chk("R4", "count eot", sect_cnt, 3);
    chk("R4", "int_code normal", int_code, 0);
    chk("R4", "xfer off", xfer_en, 0);
    chk("R7", "ma clear", st_ma, 0);
    tick();
    chk("R8", "done dropped", done, 0);
    tick(); tick(); tick();
    chk("R8", "held flags", {st_nd, st_crc, st_ma}, 3'b110);
    chk("R8", "held count", sect_cnt, 3);
    start(0, 0, 3);
    chk("R8", "flags cleared", {st_nd, st_crc, st_ma}, 0);
    chk("R8", "count cleared", sect_cnt, 0);
  endtask

  task automatic t_id_crc();
    do_reset();
    exp_id = 32'h7;
    start(0, 0, 4);
    ev_index();
    ev_id(32'h7, 1);
    chk("R6", "crc on id", st_crc, 1);
    chk("R6", "xfer after id crc", xfer_en, 1);
  endtask

  task automatic t_timeout();
    do_reset();
    exp_id = 32'h3;
    start(0, 0, 5);
    ev_index();
    ev_id(32'h3, 0);
    ev_data(0);
    ev_index();
    chk("R7", "no timeout after id", done, 0);
    ev_id(32'h3, 0);
    ev_index();
    chk("R7", "reset by id", done, 0);
    chk("R7", "still reading", xfer_en, 1);
    ev_index();
    chk("R7", "done on timeout", done, 1);
    chk("R7", "int_code abnormal", int_code, 1);
    chk("R7", "ma set", st_ma, 1);
    chk("R7", "count kept", sect_cnt, 1);
    chk("R7", "xfer off", xfer_en, 0);
  endtask

  task automatic t_start_no_id();
    do_reset();
    start(0, 0, 5);
    ev_index();
    ev_index();
    chk("R7", "timeout second index", st_ma, 1);
  endtask

  task automatic t_busy();
    do_reset();
    exp_id = 32'h1;
    start(0, 0, 2);
    ev_index();
    start(1, 0, 2);
    chk("R9", "no reject while busy", done, 0);
    chk("R9", "xfer kept", xfer_en, 1);
    ev_data(0);
    ev_data(0);
    chk("R9", "normal end", done, 1);
    chk("R9", "code normal", int_code, 0);
  endtask

  task automatic t_priority();
    do_reset();
    start(0, 0, 1);
    ev_index();
    data_end = 1; index_pulse = 1;
    tick(); clr_in();
    chk("R10", "done", done, 1);
    chk("R10", "int_code normal", int_code, 0);
    chk("R10", "ma clear", st_ma, 0);
    chk("R10", "count", sect_cnt, 1);
  endtask

  initial begin
    clr_in();
    exp_id = '0; eot_cnt = '0; rst = 1;
    t_reset();
    t_reject();
    t_normal();
    t_id_crc();
    t_timeout();
    t_start_no_id();
    t_busy();
    t_priority();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule